// File: doc/BRIEF.md
# Gated Microcontroller Clock Divider

This block takes the crystal-oscillator clock and produces the clock that feeds an external microcontroller. The divide ratio follows the band code from the receiver setup. The 315 MHz band divides by six. Every other code divides by four. The block also drives the decoded select line to the rest of the receiver.

The output stays low until the reception sequencer reports that a detection phase has begun. The clock then runs. After the second interrupt pulse of a reception sequence has ended, the block lets sixteen more output cycles go by and then parks the clock low. With the clock parked, the whole system can sit with no clock toggling. Starts, stops and ratio changes are aligned to the divider phase, so the output never carries a shortened high or low phase.

Top module: `ucclk_gen`

## Requirements
- R1: After reset `mc_clk` is low and stays low until `detect_start` is sampled high.
- R2: `div_sel_hi` is low for band code 2'b10 (315 MHz) and high for codes 2'b00, 2'b01 and 2'b11, at all times.
- R3: While running with the latched select high, `mc_clk` has a period of 4 oscillator cycles: 2 high, then 2 low.
- R4: While running with the latched select low, `mc_clk` has a period of 6 oscillator cycles: 3 high, then 3 low.
- R5: When `detect_start` is sampled high with the clock stopped, the divider starts with a full low half-period. The first rising edge follows one half-period after that clock edge.
- R6: A change of band code takes effect only at the end of an output period, at the falling edge. No period mixes the two ratios. While stopped, the current code is always the one in use.
- R7: After the second falling edge of `irq_pulse` since the sequence started, the clock completes exactly 16 further falling edges. It then stays low.
- R8: A `detect_start` during a running sequence, including during the stop countdown, cancels any countdown. It also resets the interrupt count to zero, so the clock keeps running.
- R9: Falling edges of `irq_pulse` while the clock is stopped are ignored, and so are further edges during the countdown.
- R10: The clock stops only at the end of a full high phase. Every high phase has the full half-period length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Crystal-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_code | input | 2 | Setup band field (2'b10 = 315 MHz) |
| detect_start | input | 1 | One-cycle event: a detection phase begins |
| irq_pulse | input | 1 | Interrupt line to the microcontroller |
| mc_clk | output | 1 | Gated divided clock |
| div_sel_hi | output | 1 | Decoded select: high = divide by 4 |

## Verification
The assertions check several properties on every cycle. Each high phase has a legal full length. The output is low whenever the run state is off. A start event always leaves the block running. The run state drops only together with a falling output edge. Whether the stop comes after exactly sixteen periods, whether a cancel really restarts the interrupt count, and whether interrupts are ignored while stopped depend on event history. Only the bench's scenarios, checked against its cycle-by-cycle model, can show those.

// File: rtl/ucclk_gen.sv
module ucclk_gen #(
  parameter int DIV_HI      = 4,
  parameter int DIV_LO      = 6,
  parameter int STOP_CYCLES = 16,
  parameter int IRQ_EDGES   = 2
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [1:0] band_code,
  input  logic       detect_start,
  input  logic       irq_pulse,
  output logic       mc_clk,
  output logic       div_sel_hi
);
  localparam int HALF_HI = DIV_HI / 2;
  localparam int HALF_LO = DIV_LO / 2;
  localparam int HALF_MX = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
  localparam int CW = $clog2(HALF_MX + 1);
  localparam int SW = $clog2(STOP_CYCLES + 1);
  localparam int IW = $clog2(IRQ_EDGES + 1);

  logic          run, phase, irq_d, counting;
  logic [CW-1:0] cnt, half_q;
  logic [SW-1:0] stop_left;
  logic [IW-1:0] irq_seen;

  assign div_sel_hi = (band_code != 2'b10);
  assign mc_clk     = phase;

  wire [CW-1:0] half_new   = div_sel_hi ? CW'(HALF_HI) : CW'(HALF_LO);
  wire          half_end   = run && (cnt == half_q - 1'b1);
  wire          period_end = half_end && phase;
  wire          irq_fall   = irq_d && !irq_pulse;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      phase     <= 1'b0;
      cnt       <= '0;
      half_q    <= CW'(HALF_HI);
      irq_d     <= 1'b0;
      counting  <= 1'b0;
      stop_left <= '0;
      irq_seen  <= '0;
    end else begin
      irq_d <= irq_pulse;
      if (!run) begin
        phase    <= 1'b0;
        cnt      <= '0;
        half_q   <= half_new;
        irq_seen <= '0;
        counting <= 1'b0;
        if (detect_start) run <= 1'b1;
      end else begin
        if (half_end) begin
          cnt   <= '0;
          phase <= !phase;
          if (phase) half_q <= half_new;
        end else begin
          cnt <= cnt + 1'b1;
        end

        if (detect_start) begin
          irq_seen <= '0;
          counting <= 1'b0;
        end else if (counting) begin
          if (period_end) begin
            stop_left <= stop_left - 1'b1;
            if (stop_left == SW'(1)) begin
              run      <= 1'b0;
              counting <= 1'b0;
            end
          end
        end else if (irq_fall) begin
          irq_seen <= irq_seen + 1'b1;
          if (irq_seen == IW'(IRQ_EDGES - 1)) begin
            counting  <= 1'b1;
            stop_left <= SW'(STOP_CYCLES);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ucclk_gen_chk.sv
module ucclk_gen_chk #(
  parameter int HALF_A = 2,
  parameter int HALF_B = 3
) (
  input logic clk,
  input logic rst_n,
  input logic detect_start,
  input logic mc_clk,
  input logic run
);
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (mc_clk) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  a_r10_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mc_clk) |-> (hi_len == 8'(HALF_A) || hi_len == 8'(HALF_B)));

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mc_clk);

  a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && detect_start) |=> run);

  a_r8_cancel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && detect_start) |=> run);

  a_r7_stop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $fell(mc_clk));
endmodule

bind ucclk_gen ucclk_gen_chk #(.HALF_A(DIV_HI / 2), .HALF_B(DIV_LO / 2)) u_chk (
  .clk(clk_osc), .rst_n(rst_n), .detect_start(detect_start),
  .mc_clk(mc_clk), .run(run)
);

// File: tb/ucclk_gen_tb.sv
module ucclk_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] band = 2'b00;
  logic       det = 1'b0;
  logic       irq = 1'b0;
  logic       mc_clk, sel;

  int total = 0;
  int bad = 0;

  ucclk_gen u_dut (
    .clk_osc(clk), .rst_n(rst_n), .band_code(band),
    .detect_start(det), .irq_pulse(irq),
    .mc_clk(mc_clk), .div_sel_hi(sel)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  // behavioural reference model
  int m_run = 0, m_pos = 0, m_div = 4, m_falls = 0, m_left = -1, m_prev = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_div = 4; m_falls = 0; m_left = -1; m_prev = 0;
    end else begin
      automatic bit fall = (m_prev == 1) && !irq;
      m_prev = irq ? 1 : 0;
      if (m_run == 0) begin
        m_div = (band == 2'b10) ? 6 : 4;
        if (det) begin m_run = 1; m_pos = 0; m_falls = 0; m_left = -1; end
      end else begin
        automatic bit wrap = (m_pos == m_div - 1);
        m_pos = wrap ? 0 : m_pos + 1;
        if (wrap) m_div = (band == 2'b10) ? 6 : 4;
        if (det) begin
          m_falls = 0; m_left = -1;
        end else if (m_left >= 0) begin
          if (wrap) begin
            m_left--;
            if (m_left == 0) begin m_run = 0; m_pos = 0; m_left = -1; end
          end
        end else if (fall) begin
          m_falls++;
          if (m_falls == 2) m_left = 16;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int e = (m_run != 0 && m_pos >= m_div / 2) ? 1 : 0;
      check(mc_clk == e, "R3 R4 R5 R6 R7 R8 R9 per-cycle clock", mc_clk, e);
      check(sel == (band != 2'b10), "R2 per-cycle select", sel, band != 2'b10);
    end
  end

  task automatic pulse_det();
    @(negedge clk) det = 1'b1;
    @(negedge clk) det = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk) irq = 1'b1;
    repeat (2) @(negedge clk);
    irq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_edges(input int n, output int rises, output int falls);
    automatic logic prev = mc_clk;
    rises = 0; falls = 0;
    repeat (n) begin
      @(negedge clk);
      if (mc_clk && !prev) rises++;
      if (!mc_clk && prev) falls++;
      prev = mc_clk;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int r, f;
    repeat (3) @(negedge clk);
    check(mc_clk == 1'b0, "R1 reset low", mc_clk, 0);
    rst_n = 1'b1;
    count_edges(20, r, f);
    check(r == 0, "R1 idle no edges", r, 0);

    for (int c = 0; c < 4; c++) begin
      @(negedge clk) band = 2'(c);
      #1 check(sel == (c != 2), "R2 select decode", sel, c != 2);
    end

    band = 2'b00;
    pulse_det();
    count_edges(40, r, f);
    check(r == 10, "R3 divide by 4 rate", r, 10);

    band = 2'b10;
    repeat (8) @(negedge clk);
    count_edges(60, r, f);
    check(r == 10, "R4 R6 divide by 6 rate", r, 10);

    pulse_irq();
    @(negedge clk) irq = 1'b1;
    repeat (2) @(negedge clk);
    irq = 1'b0;
    @(negedge clk);
    count_edges(200, r, f);
    check(f == 16, "R7 falls after second irq", f, 16);
    check(mc_clk == 1'b0, "R7 parked low", mc_clk, 0);

    pulse_irq(); pulse_irq(); pulse_irq();
    count_edges(30, r, f);
    check(r == 0, "R9 irq while stopped ignored", r, 0);

    band = 2'b01;
    pulse_det();
    pulse_irq();
    count_edges(150, r, f);
    check(r > 30, "R9 R5 still running after one irq", r, 37);

    pulse_irq();
    repeat (10) @(negedge clk);
    pulse_irq();
    pulse_det();
    count_edges(150, r, f);
    check(r > 30, "R8 countdown cancelled", r, 37);

    pulse_irq();
    count_edges(150, r, f);
    check(r > 30, "R8 irq count restarted", r, 37);

    pulse_irq();
    count_edges(200, r, f);
    count_edges(20, r, f);
    check(r == 0 && mc_clk == 1'b0, "R7 R10 stopped after cancel sequence", r, 0);

    summary();
  end
endmodule